// File: doc/BRIEF.md
# Hash result frame parser

This block sits behind a UART receiver on the return path from a chain of hashing engines. It watches the incoming byte stream for a two-byte sync pattern, collects the fixed-length result frame that follows, and splits it into a job id, an engine id, a sub-engine id, the nonce and the rolled version bits. The trailing check byte is consumed to close the frame but its value is not checked.

Job ids are handed out on the dispatch side by a small generator. It steps by a fixed stride around a 7-bit space and marks each issued id in a 128-entry valid table. A decoded result whose job id is absent from that table is thrown away and counted in a saturating counter. Accepted results wait in a single output register behind a valid/ready handshake. While that register is stalled, incoming bytes are discarded and a sticky overflow flag is raised.

Top module: `result_frame_parser`

## Requirements
- R1: After reset `res_valid_o`, `drop_count_o`, `overflow_o` and `job_issue_id_o` are 0, and no job id is marked valid.
- R2: Bytes received while searching for alignment produce no result until the sync pair 0xAA then 0x55 is seen.
- R3: If 0xAA is followed by a byte other than 0x55, alignment restarts from the search state. A repeated 0xAA keeps the parser waiting for 0x55, so 0xAA 0xAA 0x55 aligns.
- R4: A frame is the sync pair plus 9 body bytes, in this order: nonce (4, most significant first), midstate (1), packed job byte (1), version (2, most significant first), check byte (1). The result is valid in the cycle after the check byte is taken, whatever value the check byte has.
- R5: `res_nonce_o` is the big-endian nonce, and `res_engine_o` is its bits 31 to 25.
- R6: `res_job_id_o` equals (job byte AND 0xF0) shifted right by one, and `res_sub_o` is the job byte's low 4 bits.
- R7: `res_version_o` is the 16-bit version field shifted left by 13 into a 32-bit value.
- R8: Each `job_issue_i` pulse advances `job_issue_id_o` by 24 modulo 128, starting from 0, and marks the new id valid.
- R9: A frame whose decoded job id is not marked valid yields no result, and `drop_count_o` increments by one.
- R10: `drop_count_o` saturates at its all-ones value.
- R11: While `res_valid_o` is high and `res_ready_i` is low, the output fields stay stable. Any byte received in that time is discarded without advancing the parser, and `overflow_o` sets and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| job_issue_i | input | 1 | Allocate the next job id and mark it valid |
| job_issue_id_o | output | 7 | Most recently issued job id |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Consumer takes the result |
| res_job_id_o | output | 7 | Decoded job id |
| res_engine_o | output | 7 | Engine id from the top nonce bits |
| res_sub_o | output | 4 | Sub-engine id |
| res_nonce_o | output | 32 | Nonce, big-endian |
| res_version_o | output | 32 | Rolled version bits |
| drop_count_o | output | DROP_W | Saturating count of results with an unknown job id |
| overflow_o | output | 1 | Sticky: a byte arrived while the output was stalled |

## Verification
The hardest situation to reach is a complete, well-formed frame that arrives while the output register is stalled. The bench must show that this frame leaves no trace. To get there it holds `res_ready_i` low after a good result and streams a full frame for another valid job. It then releases the stall and confirms that no second result appears and the drop count is unchanged. Saturation of the drop counter is reached by building the bench with a narrow counter and feeding a run of frames that carry unissued job ids.

// File: rtl/rfp_pkg.sv
package rfp_pkg;
  localparam logic [7:0] SYNC_HI = 8'hAA;
  localparam logic [7:0] SYNC_LO = 8'h55;
  localparam int BODY_BYTES = 9;
  localparam int JOB_W      = 7;
  localparam int ENG_W      = 7;
  localparam int SUB_W      = 4;
  localparam int NONCE_W    = 32;
  localparam int VER_W      = 32;
  localparam int VER_SHIFT  = 13;

  typedef struct packed {
    logic [JOB_W-1:0]   job_id;
    logic [ENG_W-1:0]   engine;
    logic [SUB_W-1:0]   sub;
    logic [NONCE_W-1:0] nonce;
    logic [VER_W-1:0]   version;
  } result_t;
endpackage

// File: rtl/rfp_aligner.sv
module rfp_aligner
  import rfp_pkg::*;
#(
  parameter int BODY_N = BODY_BYTES
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      rx_valid_i,
  input  logic [7:0]                rx_data_i,
  input  logic                      hold_i,
  output logic                      frame_done_o,
  output logic [BODY_N-2:0][7:0]    body_o,
  output logic                      overflow_o
);
  localparam int CNT_W = $clog2(BODY_N);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BODY_N - 1);

  typedef enum logic [1:0] {ST_HUNT, ST_SYNC, ST_BODY} state_e;

  state_e                  state_q;
  logic [CNT_W-1:0]        cnt_q;
  logic [BODY_N-2:0][7:0]  body_q;
  logic                    ovf_q;
  logic                    accept;

  assign accept       = rx_valid_i && !hold_i;
  assign frame_done_o = accept && (state_q == ST_BODY) && (cnt_q == LAST);
  assign body_o       = body_q;
  assign overflow_o   = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
    end else if (accept) begin
      case (state_q)
        ST_HUNT: if (rx_data_i == SYNC_HI) state_q <= ST_SYNC;
        ST_SYNC: begin
          if (rx_data_i == SYNC_LO) begin
            state_q <= ST_BODY;
            cnt_q   <= '0;
          end else if (rx_data_i != SYNC_HI) begin
            state_q <= ST_HUNT;
          end
        end
        ST_BODY: begin
          if (cnt_q == LAST) state_q <= ST_HUNT;
          else               cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end

  // check byte is consumed but never stored
  for (genvar g = 0; g < BODY_N - 1; g++) begin : g_body
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) body_q[g] <= '0;
      else if (accept && state_q == ST_BODY && cnt_q == CNT_W'(g)) body_q[g] <= rx_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      ovf_q <= 1'b0;
    else if (rx_valid_i && hold_i)    ovf_q <= 1'b1;
  end

  AST_HOLD_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(state_q) && $stable(cnt_q)); // R11
  AST_SYNC_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && state_q == ST_SYNC && rx_data_i != SYNC_LO && rx_data_i != SYNC_HI)
      |=> state_q == ST_HUNT); // R3
endmodule

// File: rtl/rfp_decode.sv
module rfp_decode
  import rfp_pkg::*;
#(
  parameter int BODY_N = BODY_BYTES
) (
  input  logic [BODY_N-2:0][7:0] body_i,
  output result_t                res_o
);
  logic [7:0]  job_byte;
  logic [7:0]  job_mask;
  logic [15:0] ver_raw;

  assign job_byte = body_i[5];
  assign job_mask = job_byte & 8'hF0;
  assign ver_raw  = {body_i[6], body_i[7]};

  always_comb begin
    res_o.nonce   = {body_i[0], body_i[1], body_i[2], body_i[3]};
    res_o.engine  = res_o.nonce[NONCE_W-1 -: ENG_W];
    res_o.job_id  = JOB_W'(job_mask >> 1);
    res_o.sub     = job_byte[SUB_W-1:0];
    res_o.version = VER_W'(ver_raw) << VER_SHIFT;
  end
endmodule

// File: rtl/rfp_job_table.sv
module rfp_job_table #(
  parameter int ID_W = 7,
  parameter int STEP = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            issue_i,
  output logic [ID_W-1:0] issue_id_o,
  input  logic [ID_W-1:0] look_id_i,
  output logic            look_ok_o
);
  localparam int DEPTH = 1 << ID_W;
  localparam logic [ID_W-1:0] STEP_V = ID_W'(STEP);

  logic [ID_W-1:0]  id_q;
  logic [ID_W-1:0]  next_id;
  logic [DEPTH-1:0] valid_q;

  assign next_id    = id_q + STEP_V;
  assign issue_id_o = id_q;
  assign look_ok_o  = valid_q[look_id_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_q    <= '0;
      valid_q <= '0;
    end else if (issue_i) begin
      id_q             <= next_id;
      valid_q[next_id] <= 1'b1;
    end
  end

  AST_ISSUE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |=> issue_id_o == ID_W'($past(issue_id_o) + STEP_V)); // R8
  AST_ISSUED_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |=> valid_q[issue_id_o]); // R8
endmodule

// File: rtl/rfp_out_stage.sv
module rfp_out_stage
  import rfp_pkg::*;
#(
  parameter int DROP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              drop_i,
  input  result_t           res_i,
  input  logic              ready_i,
  output logic              valid_o,
  output result_t           res_o,
  output logic              hold_o,
  output logic [DROP_W-1:0] drop_cnt_o
);
  localparam logic [DROP_W-1:0] CNT_MAX = {DROP_W{1'b1}};

  logic              valid_q;
  result_t           res_q;
  logic [DROP_W-1:0] cnt_q;

  assign valid_o    = valid_q;
  assign res_o      = res_q;
  assign hold_o     = valid_q && !ready_i;
  assign drop_cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      res_q   <= res_i;
    end else if (ready_i) begin
      valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (drop_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !ready_i) |=> valid_q && $stable(res_q)); // R11
  AST_DROP_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX); // R10
  AST_DROP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1); // R9
endmodule

// File: rtl/result_frame_parser.sv
module result_frame_parser
  import rfp_pkg::*;
#(
  parameter int DROP_W  = 8,
  parameter int ID_STEP = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rx_valid_i,
  input  logic [7:0]          rx_data_i,
  input  logic                job_issue_i,
  output logic [JOB_W-1:0]    job_issue_id_o,
  output logic                res_valid_o,
  input  logic                res_ready_i,
  output logic [JOB_W-1:0]    res_job_id_o,
  output logic [ENG_W-1:0]    res_engine_o,
  output logic [SUB_W-1:0]    res_sub_o,
  output logic [NONCE_W-1:0]  res_nonce_o,
  output logic [VER_W-1:0]    res_version_o,
  output logic [DROP_W-1:0]   drop_count_o,
  output logic                overflow_o
);
  logic                        frame_done;
  logic [BODY_BYTES-2:0][7:0]  body;
  logic                        hold;
  logic                        job_ok;
  result_t                     dec_res;
  result_t                     out_res;

  rfp_aligner #(.BODY_N(BODY_BYTES)) u_aligner (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rx_valid_i   (rx_valid_i),
    .rx_data_i    (rx_data_i),
    .hold_i       (hold),
    .frame_done_o (frame_done),
    .body_o       (body),
    .overflow_o   (overflow_o)
  );

  rfp_decode #(.BODY_N(BODY_BYTES)) u_decode (
    .body_i (body),
    .res_o  (dec_res)
  );

  rfp_job_table #(.ID_W(JOB_W), .STEP(ID_STEP)) u_jobs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .issue_i    (job_issue_i),
    .issue_id_o (job_issue_id_o),
    .look_id_i  (dec_res.job_id),
    .look_ok_o  (job_ok)
  );

  rfp_out_stage #(.DROP_W(DROP_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (frame_done && job_ok),
    .drop_i     (frame_done && !job_ok),
    .res_i      (dec_res),
    .ready_i    (res_ready_i),
    .valid_o    (res_valid_o),
    .res_o      (out_res),
    .hold_o     (hold),
    .drop_cnt_o (drop_count_o)
  );

  assign res_job_id_o  = out_res.job_id;
  assign res_engine_o  = out_res.engine;
  assign res_sub_o     = out_res.sub;
  assign res_nonce_o   = out_res.nonce;
  assign res_version_o = out_res.version;

  AST_VALID_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done && job_ok) |=> res_valid_o); // R4
  AST_INVALID_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done && !job_ok) |=> !res_valid_o); // R9
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o); // R11
endmodule

// File: tb/result_frame_parser_tb.sv
`timescale 1ns/1ps
module result_frame_parser_tb;
  localparam int DW = 4;
  localparam logic [DW-1:0] DMAX = {DW{1'b1}};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_valid_i = 1'b0;
  logic [7:0]  rx_data_i = '0;
  logic        job_issue_i = 1'b0;
  logic [6:0]  job_issue_id_o;
  logic        res_valid_o;
  logic        res_ready_i = 1'b0;
  logic [6:0]  res_job_id_o;
  logic [6:0]  res_engine_o;
  logic [3:0]  res_sub_o;
  logic [31:0] res_nonce_o;
  logic [31:0] res_version_o;
  logic [DW-1:0] drop_count_o;
  logic        overflow_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [6:0]    exp_id = '0;
  logic [DW-1:0] exp_drop = '0;

  always #2 clk_i = ~clk_i;

  result_frame_parser #(.DROP_W(DW), .ID_STEP(24)) u_dut (.*);

  // {expect_ok, nonce, midstate, job byte, version}
  localparam logic [64:0] VEC [6] = '{
    {1'b1, 32'hFE00_1234, 8'h01, 8'h35, 16'h0001},
    {1'b1, 32'h0200_0000, 8'h00, 8'h6F, 16'hFFFF},
    {1'b1, 32'h8000_0001, 8'h07, 8'h90, 16'h1234},
    {1'b0, 32'h1111_1111, 8'h00, 8'h1A, 16'h0000},
    {1'b1, 32'hDEAD_BEEF, 8'h01, 8'h3F, 16'h00AA},
    {1'b0, 32'h0000_0000, 8'h00, 8'h08, 16'h0000}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk_i);
    rx_valid_i = 1'b1;
    rx_data_i  = b;
    @(posedge clk_i);
    #1 rx_valid_i = 1'b0;
  endtask

  function automatic logic [7:0] fbyte(input int i, input logic [31:0] n, input logic [7:0] m,
                                       input logic [7:0] j, input logic [15:0] v, input logic [7:0] c);
    case (i)
      0: return 8'hAA;  1: return 8'h55;
      2: return n[31:24]; 3: return n[23:16]; 4: return n[15:8]; 5: return n[7:0];
      6: return m; 7: return j; 8: return v[15:8]; 9: return v[7:0];
      default: return c;
    endcase
  endfunction

  task automatic send_frame(input logic [31:0] n, input logic [7:0] m, input logic [7:0] j,
                            input logic [15:0] v, input logic [7:0] c);
    for (int i = 0; i < 11; i++) send_byte(fbyte(i, n, m, j, v, c));
  endtask

  task automatic pop();
    @(negedge clk_i);
    res_ready_i = 1'b1;
    @(posedge clk_i);
    #1 res_ready_i = 1'b0;
  endtask

  task automatic issue();
    @(negedge clk_i);
    job_issue_i = 1'b1;
    @(posedge clk_i);
    #1 job_issue_i = 1'b0;
    exp_id = 7'((int'(exp_id) + 24) % 128);
    @(negedge clk_i);
    check(job_issue_id_o == exp_id, "R8 issue id", 32'(job_issue_id_o), 32'(exp_id));
  endtask

  task automatic check_result(input logic [31:0] n, input logic [7:0] j, input logic [15:0] v, input string tag);
    logic [7:0] jm;
    jm = j & 8'hF0;
    check(res_valid_o == 1'b1, {tag, " R4 valid"}, 32'(res_valid_o), 32'd1);
    check(res_nonce_o == n, {tag, " R5 nonce"}, res_nonce_o, n);
    check(res_engine_o == 7'(n >> 25), {tag, " R5 engine"}, 32'(res_engine_o), n >> 25);
    check(res_job_id_o == 7'(jm >> 1), {tag, " R6 job"}, 32'(res_job_id_o), 32'(jm >> 1));
    check(res_sub_o == j[3:0], {tag, " R6 sub"}, 32'(res_sub_o), 32'(j[3:0]));
    check(res_version_o == (32'(v) << 13), {tag, " R7 version"}, res_version_o, 32'(v) << 13);
  endtask

  task automatic bump_drop();
    if (exp_drop != DMAX) exp_drop = exp_drop + 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i);
    check(res_valid_o == 0, "R1 res_valid", 32'(res_valid_o), 0);
    check(drop_count_o == 0, "R1 drop", 32'(drop_count_o), 0);
    check(overflow_o == 0, "R1 overflow", 32'(overflow_o), 0);
    check(job_issue_id_o == 0, "R1 issue id", 32'(job_issue_id_o), 0);

    // R1: nothing is valid after reset, id 24 frame is dropped
    send_frame(32'h0, 8'h0, 8'h30, 16'h0, 8'h00);
    @(negedge clk_i);
    bump_drop();
    check(res_valid_o == 0, "R1 unissued id dropped", 32'(res_valid_o), 0);
    check(drop_count_o == exp_drop, "R1 drop count", 32'(drop_count_o), 32'(exp_drop));

    for (int i = 0; i < 3; i++) issue(); // 24, 48, 72

    // R2: noise before alignment produces nothing
    send_byte(8'h55); send_byte(8'h12); send_byte(8'h00);
    @(negedge clk_i);
    check(res_valid_o == 0, "R2 noise ignored", 32'(res_valid_o), 0);

    for (int i = 0; i < 6; i++) begin
      send_frame(VEC[i][63:32], VEC[i][31:24], VEC[i][23:16], VEC[i][15:0], 8'(i * 37));
      @(negedge clk_i);
      if (VEC[i][64]) begin
        check_result(VEC[i][63:32], VEC[i][23:16], VEC[i][15:0], $sformatf("vec%0d", i));
        pop();
        @(negedge clk_i);
        check(res_valid_o == 0, "R4 popped", 32'(res_valid_o), 0);
      end else begin
        bump_drop();
        check(res_valid_o == 0, "R9 no result", 32'(res_valid_o), 0);
        check(drop_count_o == exp_drop, "R9 drop count", 32'(drop_count_o), 32'(exp_drop));
      end
    end

    // R4: not valid before the check byte, valid just after it
    for (int i = 0; i < 10; i++) send_byte(fbyte(i, 32'hCAFE_0001, 8'h02, 8'h61, 16'h0102, 8'hAA));
    @(negedge clk_i);
    check(res_valid_o == 0, "R4 early", 32'(res_valid_o), 0);
    send_byte(8'hAA);
    @(negedge clk_i);
    check_result(32'hCAFE_0001, 8'h61, 16'h0102, "R4 timing");
    pop();

    // R3: AA then non-55 breaks alignment
    send_byte(8'hAA); send_byte(8'h13); send_byte(8'h55);
    for (int i = 2; i < 11; i++) send_byte(fbyte(i, 32'h0102_0304, 8'h01, 8'h31, 16'h0001, 8'h00));
    @(negedge clk_i);
    check(res_valid_o == 0, "R3 broken sync", 32'(res_valid_o), 0);
    check(drop_count_o == exp_drop, "R3 no frame seen", 32'(drop_count_o), 32'(exp_drop));
    send_byte(8'hAA);
    send_frame(32'h0102_0304, 8'h01, 8'h31, 16'h0001, 8'h00);
    @(negedge clk_i);
    check_result(32'h0102_0304, 8'h31, 16'h0001, "R3 AA AA 55");
    pop();

    // R8: wrap of the id space
    for (int i = 0; i < 5; i++) issue(); // 96, 120, 16, 40, 64
    send_frame(32'h7700_0000, 8'h00, 8'h22, 16'h0003, 8'h11);
    @(negedge clk_i);
    check_result(32'h7700_0000, 8'h22, 16'h0003, "R8 wrapped id 16");
    pop();

    // R10: saturation
    for (int i = 0; i < 16; i++) begin
      send_frame(32'h0, 8'h0, 8'h00, 16'h0, 8'h00);
      bump_drop();
    end
    @(negedge clk_i);
    check(drop_count_o == DMAX, "R10 saturated", 32'(drop_count_o), 32'(DMAX));
    send_frame(32'h0, 8'h0, 8'h00, 16'h0, 8'h00);
    @(negedge clk_i);
    check(drop_count_o == DMAX, "R10 stays saturated", 32'(drop_count_o), 32'(DMAX));

    // R11: stall drops a whole incoming frame
    send_frame(32'h1357_9BDF, 8'h00, 8'h30, 16'h0010, 8'h00);
    @(negedge clk_i);
    check_result(32'h1357_9BDF, 8'h30, 16'h0010, "R11 held");
    check(overflow_o == 0, "R11 no overflow yet", 32'(overflow_o), 0);
    send_frame(32'h2468_ACE0, 8'h00, 8'h60, 16'h0020, 8'h00);
    @(negedge clk_i);
    check(overflow_o == 1, "R11 overflow set", 32'(overflow_o), 1);
    check(res_nonce_o == 32'h1357_9BDF, "R11 stable", res_nonce_o, 32'h1357_9BDF);
    pop();
    repeat (4) @(negedge clk_i);
    check(res_valid_o == 0, "R11 stalled frame discarded", 32'(res_valid_o), 0);
    check(overflow_o == 1, "R11 overflow sticky", 32'(overflow_o), 1);
    send_frame(32'h2468_ACE0, 8'h00, 8'h60, 16'h0020, 8'h00);
    @(negedge clk_i);
    check_result(32'h2468_ACE0, 8'h60, 16'h0020, "R11 after release");
    pop();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule